// File: doc/BRIEF.md
# Multibit Enable Synchronizer

This block brings a 4-bit, redundantly encoded enable into a new clock domain. The encoding uses two complementary patterns: the active value is `4'b1010` and the inactive value is `4'b0101`. Every bit changes exactly once when the signal moves between these two values. Because of that, a separate two-flop synchronizer on each bit is enough: the function it controls cannot flicker back and forth while the bits settle.

After the synchronizer, the block drives a configurable number of separately registered copies of the synchronized word. It also decodes copy 0 four ways: strict-true, loose-true, strict-false and loose-false. It reports whether every copy is exactly active. Finally, it produces one fail-safe enable whose rule depends on the polarity mode:
- In normal mode, only the exact active pattern seen on two copies turns the function on.
- In escalate mode, anything other than the exact inactive pattern turns the function on.

Reset loads each flop with the safe value for the selected mode.

Top module: `mb_enable_sync`

## Requirements
- R1: In normal mode (POLARITY = POL_NORMAL), while reset is high and until three clock edges after it drops, every copy reads `4'b0101` and the enable output is 0.
- R2: In escalate mode (POLARITY = POL_ESCALATE), while reset is high and until three clock edges after it drops, every copy reads `4'b1010` and the enable output is 1.
- R3: After reset, the value on `sig_i` at a rising edge appears on the copy outputs after the third rising edge counted from that one (edges k, k+1, k+2), with no other delay.
- R4: Copy n occupies bits [4n+3:4n] of `copies_o`, and every copy carries the same synchronized word.
- R5: `true_strict_o` is 1 exactly when copy 0 equals `4'b1010`.
- R6: `true_loose_o` is 1 exactly when copy 0 differs from `4'b0101`.
- R7: `false_strict_o` is 1 exactly when copy 0 equals `4'b0101`.
- R8: `false_loose_o` is 1 exactly when copy 0 differs from `4'b1010`.
- R9: `all_true_o` is 1 exactly when every copy equals `4'b1010`.
- R10: In normal mode, `enable_o` is 1 only when copies 0 and 1 both equal `4'b1010`. In escalate mode, `enable_o` is 1 whenever copy 0 differs from `4'b0101`. Any invalid pattern therefore leaves a normal function off and an escalation function on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sig_i | input | 4 | Encoded enable from the source domain |
| copies_o | output | 4*NCOPY | Registered copies of the synchronized word, copy n at [4n+3:4n] |
| true_strict_o | output | 1 | Copy 0 is exactly the active pattern |
| true_loose_o | output | 1 | Copy 0 is anything but the inactive pattern |
| false_strict_o | output | 1 | Copy 0 is exactly the inactive pattern |
| false_loose_o | output | 1 | Copy 0 is anything but the active pattern |
| all_true_o | output | 1 | Every copy is exactly the active pattern |
| enable_o | output | 1 | Fail-safe enable for the selected polarity mode |

## Verification
The assertions check several relations on every cycle:
- the three-edge latency from `sig_i` to copy 0;
- the reset value seen right after reset;
- that the strict and loose flags are consistent with each other;
- that `enable_o` never opposes the flag it depends on.

Other behaviour can only be shown by the bench's scenarios, run on a normal-mode and an escalate-mode instance:
- the exact decode of each invalid pattern (all zeros, all ones, single-bit and three-bit variants);
- one-cycle glitches and rapid toggling;
- a reset taken while the signal is active.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int MBW = 4;

    typedef logic [MBW-1:0] mb_word_t;

    localparam mb_word_t MB_ON  = 4'b1010;
    localparam mb_word_t MB_OFF = 4'b0101;

    typedef enum logic {
        POL_NORMAL   = 1'b0,
        POL_ESCALATE = 1'b1
    } pol_e;

    typedef struct packed {
        logic t_strict;
        logic t_loose;
        logic f_strict;
        logic f_loose;
    } mb_flags_t;

    // Value every flop takes in reset: the state that is safe for the mode.
    function automatic mb_word_t safe_word(input pol_e pol);
        return (pol == POL_ESCALATE) ? MB_ON : MB_OFF;
    endfunction

    function automatic logic is_true_strict(input mb_word_t w);
        return w == MB_ON;
    endfunction

    function automatic logic is_true_loose(input mb_word_t w);
        return w != MB_OFF;
    endfunction

    function automatic logic is_false_strict(input mb_word_t w);
        return w == MB_OFF;
    endfunction

    function automatic logic is_false_loose(input mb_word_t w);
        return w != MB_ON;
    endfunction

    function automatic mb_flags_t decode_word(input mb_word_t w);
        mb_flags_t f;
        f.t_strict = is_true_strict(w);
        f.t_loose  = is_true_loose(w);
        f.f_strict = is_false_strict(w);
        f.f_loose  = is_false_loose(w);
        return f;
    endfunction

endpackage

// File: rtl/mbs_sync.sv
// Two-flop synchronizer, one independent chain per bit of the word.
module mbs_sync
    import mbs_pkg::*;
#(
    parameter mb_word_t RST_VAL = MB_OFF
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  mb_word_t d_i,
    output mb_word_t q_o
);

    for (genvar b = 0; b < MBW; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                stab_q <= meta_q;
            end
        end

        assign q_o[b] = stab_q;
    end

endmodule

// File: rtl/mbs_fanout.sv
// Separately registered copies of the synchronized word.
module mbs_fanout
    import mbs_pkg::*;
#(
    parameter int       NCOPY   = 3,
    parameter mb_word_t RST_VAL = MB_OFF
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  mb_word_t               d_i,
    output logic [NCOPY*MBW-1:0]   q_o
);

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        mb_word_t copy_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                copy_q <= RST_VAL;
            end else begin
                copy_q <= d_i;
            end
        end

        assign q_o[c*MBW +: MBW] = copy_q;
    end

endmodule

// File: rtl/mbs_decode.sv
// Four-way decode of one copy.
module mbs_decode
    import mbs_pkg::*;
(
    input  mb_word_t  w_i,
    output mb_flags_t flags_o
);

    always_comb begin
        flags_o = decode_word(w_i);
    end

endmodule

// File: rtl/mb_enable_sync.sv
module mb_enable_sync
    import mbs_pkg::*;
#(
    parameter int   NCOPY    = 3,
    parameter pol_e POLARITY = POL_NORMAL
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [3:0]           sig_i,
    output logic [NCOPY*4-1:0]   copies_o,
    output logic                 true_strict_o,
    output logic                 true_loose_o,
    output logic                 false_strict_o,
    output logic                 false_loose_o,
    output logic                 all_true_o,
    output logic                 enable_o
);

    localparam mb_word_t RST_WORD = safe_word(POLARITY);

    mb_word_t              sync_w;
    logic [NCOPY*MBW-1:0]  copy_bus;
    mb_flags_t             flags [NCOPY];
    logic [NCOPY-1:0]      strict_vec;

    mbs_sync #(
        .RST_VAL (RST_WORD)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (sig_i),
        .q_o   (sync_w)
    );

    mbs_fanout #(
        .NCOPY   (NCOPY),
        .RST_VAL (RST_WORD)
    ) u_fanout (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (sync_w),
        .q_o   (copy_bus)
    );

    for (genvar c = 0; c < NCOPY; c++) begin : g_dec
        mbs_decode u_dec (
            .w_i     (copy_bus[c*MBW +: MBW]),
            .flags_o (flags[c])
        );
        assign strict_vec[c] = flags[c].t_strict;
    end

    assign copies_o       = copy_bus;
    assign true_strict_o  = flags[0].t_strict;
    assign true_loose_o   = flags[0].t_loose;
    assign false_strict_o = flags[0].f_strict;
    assign false_loose_o  = flags[0].f_loose;
    assign all_true_o     = &strict_vec;

    if (POLARITY == POL_ESCALATE) begin : g_esc
        assign enable_o = flags[0].t_loose;
    end else if (NCOPY >= 2) begin : g_norm_dual
        assign enable_o = strict_vec[0] & strict_vec[1];
    end else begin : g_norm_single
        assign enable_o = strict_vec[0];
    end

endmodule

// File: rtl/mb_enable_sync_chk.sv
module mb_enable_sync_chk
    import mbs_pkg::*;
#(
    parameter int   NCOPY    = 3,
    parameter pol_e POLARITY = POL_NORMAL
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic [3:0] sig_i,
    input logic [3:0] copy0,
    input logic       true_strict_o,
    input logic       true_loose_o,
    input logic       false_strict_o,
    input logic       false_loose_o,
    input logic       all_true_o,
    input logic       enable_o
);

    localparam mb_word_t RST_WORD = safe_word(POLARITY);

    logic [1:0] run_q   = 2'd0;
    logic       was_rst = 1'b0;

    always_ff @(posedge clk_i) begin
        was_rst <= rst_i;
        if (rst_i) begin
            run_q <= 2'd0;
        end else if (run_q != 2'd3) begin
            run_q <= run_q + 2'd1;
        end
    end

    // R1 / R2: first cycle after reset shows the safe word
    always_ff @(posedge clk_i) begin
        if (was_rst && !rst_i) begin
            p_reset_safe_r1: assert (copy0 == RST_WORD)
                else $error("copy0 not safe after reset");
        end
    end

    p_latency_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q == 2'd3) |-> (copy0 == $past(sig_i, 3)));

    p_strict_implies_loose_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        true_strict_o |-> (true_loose_o && !false_loose_o));

    p_loose_cover_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (true_loose_o || false_loose_o));

    p_strict_exclusive_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(true_strict_o && false_strict_o));

    p_false_strict_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        false_strict_o |-> (false_loose_o && !true_loose_o));

    p_all_true_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        all_true_o |-> true_strict_o);

    if (POLARITY == POL_ESCALATE) begin : g_esc_chk
        p_esc_enable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
            !false_strict_o |-> enable_o);
    end else begin : g_norm_chk
        p_norm_enable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
            enable_o |-> true_strict_o);
    end

endmodule

bind mb_enable_sync mb_enable_sync_chk #(
    .NCOPY    (NCOPY),
    .POLARITY (POLARITY)
) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .sig_i          (sig_i),
    .copy0          (copies_o[3:0]),
    .true_strict_o  (true_strict_o),
    .true_loose_o   (true_loose_o),
    .false_strict_o (false_strict_o),
    .false_loose_o  (false_loose_o),
    .all_true_o     (all_true_o),
    .enable_o       (enable_o)
);

// File: tb/mb_enable_sync_tb.sv
module mb_enable_sync_tb;
    import mbs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC_N = 3;
    localparam int NC_E = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] sig = 4'b0101;

    logic [NC_N*4-1:0] cp_n;
    logic [NC_E*4-1:0] cp_e;
    logic ts_n, tl_n, fs_n, fl_n, at_n, en_n;
    logic ts_e, tl_e, fs_e, fl_e, at_e, en_e;

    int checks = 0;
    int errors = 0;

    logic [3:0] hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mb_enable_sync #(.NCOPY(NC_N), .POLARITY(POL_NORMAL)) u_dut (
        .clk_i(clk), .rst_i(rst), .sig_i(sig), .copies_o(cp_n),
        .true_strict_o(ts_n), .true_loose_o(tl_n), .false_strict_o(fs_n),
        .false_loose_o(fl_n), .all_true_o(at_n), .enable_o(en_n));

    mb_enable_sync #(.NCOPY(NC_E), .POLARITY(POL_ESCALATE)) u_dut_esc (
        .clk_i(clk), .rst_i(rst), .sig_i(sig), .copies_o(cp_e),
        .true_strict_o(ts_e), .true_loose_o(tl_e), .false_strict_o(fs_e),
        .false_loose_o(fl_e), .all_true_o(at_e), .enable_o(en_e));

    // Reference: history of inputs accepted since the last reset
    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
        end else begin
            hist.push_back(sig);
            if (hist.size() > 3) void'(hist.pop_front());
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [3:0] en_w, ee_w;
        bit warm;
        warm = (hist.size() >= 3);
        en_w = warm ? hist[0] : 4'b0101;
        ee_w = warm ? hist[0] : 4'b1010;
        for (int c = 0; c < NC_N; c++)
            chk(warm ? "R3/R4 normal copy" : "R1 normal copy", cp_n[c*4 +: 4], en_w);
        for (int c = 0; c < NC_E; c++)
            chk(warm ? "R3/R4 escalate copy" : "R2 escalate copy", cp_e[c*4 +: 4], ee_w);
        chk("R5 strict true", {3'b0, ts_n}, {3'b0, en_w == 4'b1010});
        chk("R6 loose true",  {3'b0, tl_n}, {3'b0, en_w != 4'b0101});
        chk("R7 strict false", {3'b0, fs_n}, {3'b0, en_w == 4'b0101});
        chk("R8 loose false", {3'b0, fl_n}, {3'b0, en_w != 4'b1010});
        chk("R9 all true",    {3'b0, at_n}, {3'b0, en_w == 4'b1010});
        chk("R5 esc strict true", {3'b0, ts_e}, {3'b0, ee_w == 4'b1010});
        chk("R6 esc loose true",  {3'b0, tl_e}, {3'b0, ee_w != 4'b0101});
        chk("R7 esc strict false", {3'b0, fs_e}, {3'b0, ee_w == 4'b0101});
        chk("R8 esc loose false",  {3'b0, fl_e}, {3'b0, ee_w != 4'b1010});
        chk("R9 esc all true",     {3'b0, at_e}, {3'b0, ee_w == 4'b1010});
        chk(warm ? "R10 normal enable" : "R1 normal enable", {3'b0, en_n}, {3'b0, en_w == 4'b1010});
        chk(warm ? "R10 escalate enable" : "R2 escalate enable", {3'b0, en_e}, {3'b0, ee_w != 4'b0101});
    endtask

    task automatic step(input logic [3:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            sig = v;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] bad [6] = '{4'b0000, 4'b1111, 4'b1000, 4'b0111, 4'b1011, 4'b0100};
        // R1 / R2: reset state
        rst = 1'b1;
        step(4'b1010, 3);
        @(negedge clk);
        compare_all();
        sig = 4'b0101;
        rst = 1'b0;
        // R3: warm-up and steady OFF
        step(4'b0101, 5);
        // ON / OFF transitions
        step(4'b1010, 6);
        step(4'b0101, 6);
        // Invalid patterns: normal stays off, escalate goes on (R10)
        foreach (bad[k]) step(bad[k], 5);
        // One-cycle glitch to ON, then OFF
        step(4'b0101, 4);
        step(4'b1010, 1);
        step(4'b0101, 5);
        // Rapid toggling
        for (int i = 0; i < 8; i++) step((i % 2) ? 4'b0101 : 4'b1010, 1);
        step(4'b1010, 6);
        // Reset while active: outputs return to safe value (R1, R2)
        @(negedge clk);
        compare_all();
        rst = 1'b1;
        step(4'b1010, 3);
        @(negedge clk);
        compare_all();
        rst = 1'b0;
        step(4'b1010, 6);
        step(4'b0101, 5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule